// File: doc/BRIEF.md
# Low-Power Wake and Vector Controller

This block manages the two low-power modes of a small CPU and decides how each one ends. From its normal running state the CPU can request a wait mode, which stops only the CPU clock, or a stop mode, which also turns off the periodic timebase unless a configuration bit keeps the oscillator running. While the CPU is halted, the block watches the wake sources. Some of them force a reset: the external reset pin, a watchdog timeout and a low-voltage trip. The others are interrupts: a break request, a falling edge on the external interrupt pin, a clock-generator request and the timebase tick.

When a source wins, the block turns the CPU clock back on. It then presents the winning source's vector to the CPU as a pair of byte addresses on two consecutive strobed cycles. It also marks whether that fetch is a reset or an interrupt. The CPU is denied access to the timebase register for the whole of stop mode. Reset sources act from any state. While a reset source is held, the CPU clock stays off, and the reset vector is fetched once every reset source has gone away.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: While `por_n` is low, `cpu_clk_en` and `vec_stb` are 0. In the cycle after `por_n` rises, the reset vector fetch begins: `vec_addr`=16'hFFFE with `vec_is_rst`=1, then 16'hFFFF.
- R2: In the running state, `wait_req` turns `cpu_clk_en` off at the next clock edge and `stop_req` does the same. If both are high, stop mode is entered.
- R3: A vector fetch lasts exactly two strobed cycles. The first presents the high-byte address and the second presents that address plus one. `cpu_clk_en` is 1 during both cycles and the CPU runs after them.
- R4: The vector high-byte addresses are: break 16'hFFFC, external interrupt 16'hFFFA, clock-generator interrupt 16'hFFF8, timebase tick 16'hFFF6. `vec_is_rst` is 0 for all of these.
- R5: A wake is decided on the first clock edge at which the block is halted and a source is present. If several sources are present, the order is: reset sources, then break, then external interrupt, then clock-generator interrupt, then timebase tick.
- R6: A falling edge on `irq_n` passes through a two-flop synchronizer and is latched. The latch is cleared only when the external interrupt vector is fetched, so an edge that a higher-priority source outranks stays pending. A pin held low does not trigger a wake a second time.
- R7: In stop mode the clock-generator request is ignored. The timebase tick wakes the CPU from stop only when `osc_in_stop`=1. In wait mode both of them wake the CPU.
- R8: `tb_clk_en` is 0 exactly when the block is in stop mode with `osc_in_stop`=0.
- R9: `tb_reg_en` is 0 exactly while the block is in stop mode.
- R10: A watchdog timeout, a low-voltage trip or a low `ext_rst_n` turns `cpu_clk_en` off at the next edge from any state, including stop. It holds the CPU halted while the source stays active, outranks any interrupt present, clears a pending edge, and is followed by the reset vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset of the block, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| irq_n | input | 1 | External interrupt pin, active on a falling edge |
| brk_req | input | 1 | Break interrupt request |
| wdog_to | input | 1 | Watchdog timeout |
| lvi_trip | input | 1 | Supply below threshold |
| cgen_irq | input | 1 | Clock-generator interrupt request |
| tb_tick | input | 1 | Periodic timebase tick |
| osc_in_stop | input | 1 | Keep oscillator and timebase running in stop |
| wait_req | input | 1 | CPU requests wait mode |
| stop_req | input | 1 | CPU requests stop mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| tb_clk_en | output | 1 | Timebase clock enable |
| tb_reg_en | output | 1 | CPU access to the timebase register allowed |
| vec_is_rst | output | 1 | Current vector fetch is a reset |
| vec_stb | output | 1 | Vector address valid |
| vec_addr | output | 16 | Vector byte address |

## Verification
The hardest situation to reach is an external interrupt edge that stays pending because a higher-priority source outranked it. The edge is then served only on a later entry into a low-power mode. The stimulus sweeps every mix of break, interrupt edge, clock-generator request and tick, in both modes and for both oscillator settings. The edge is made in the running state before each halt. The bench carries a model of the pending latch from one sweep point to the next, so a leftover edge must show up as an interrupt vector on the following halt. Each sweep point where nothing should wake the CPU is followed by a break wake, which returns the block to the running state without touching the latch.

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl #(
  parameter int          SYNC     = 2,
  parameter logic [15:0] VEC_RST  = 16'hFFFE,
  parameter logic [15:0] VEC_BRK  = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ  = 16'hFFFA,
  parameter logic [15:0] VEC_CGEN = 16'hFFF8,
  parameter logic [15:0] VEC_TICK = 16'hFFF6
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        ext_rst_n,
  input  logic        irq_n,
  input  logic        brk_req,
  input  logic        wdog_to,
  input  logic        lvi_trip,
  input  logic        cgen_irq,
  input  logic        tb_tick,
  input  logic        osc_in_stop,
  input  logic        wait_req,
  input  logic        stop_req,
  output logic        cpu_clk_en,
  output logic        tb_clk_en,
  output logic        tb_reg_en,
  output logic        vec_is_rst,
  output logic        vec_stb,
  output logic [15:0] vec_addr
);

  typedef enum logic [2:0] {S_RST, S_RUN, S_WAIT, S_STOP, S_FHI, S_FLO} st_t;

  st_t         st;
  logic [SYNC:0] irq_sh;
  logic        irq_pend;
  logic [15:0] vbase;
  logic        vrst;

  wire any_rst = ~ext_rst_n | wdog_to | lvi_trip;
  wire halted  = (st == S_WAIT) | (st == S_STOP);
  wire irq_fall = irq_sh[SYNC] & ~irq_sh[SYNC-1];

  wire w_brk  = brk_req;
  wire w_irq  = irq_pend;
  wire w_cgen = cgen_irq & (st == S_WAIT);
  wire w_tick = tb_tick & ((st == S_WAIT) | osc_in_stop);
  wire wake   = halted & (w_brk | w_irq | w_cgen | w_tick);
  wire irq_ack = wake & ~w_brk & w_irq;

  logic [15:0] wake_vec;
  always_comb begin
    if (w_brk)       wake_vec = VEC_BRK;
    else if (w_irq)  wake_vec = VEC_IRQ;
    else if (w_cgen) wake_vec = VEC_CGEN;
    else             wake_vec = VEC_TICK;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= S_RST;
      irq_sh   <= '1;
      irq_pend <= 1'b0;
      vbase    <= VEC_RST;
      vrst     <= 1'b1;
    end else begin
      irq_sh <= {irq_sh[SYNC-1:0], irq_n};
      if (any_rst) begin
        st       <= S_RST;
        irq_pend <= 1'b0;
      end else begin
        irq_pend <= (irq_pend & ~irq_ack) | irq_fall;
        case (st)
          S_RST: begin
            st    <= S_FHI;
            vbase <= VEC_RST;
            vrst  <= 1'b1;
          end
          S_RUN: begin
            if (stop_req)      st <= S_STOP;
            else if (wait_req) st <= S_WAIT;
          end
          S_WAIT, S_STOP: begin
            if (wake) begin
              st    <= S_FHI;
              vbase <= wake_vec;
              vrst  <= 1'b0;
            end
          end
          S_FHI:   st <= S_FLO;
          default: st <= S_RUN;
        endcase
      end
    end
  end

  assign cpu_clk_en = (st == S_RUN) | vec_stb;
  assign tb_clk_en  = ~((st == S_STOP) & ~osc_in_stop);
  assign tb_reg_en  = (st != S_STOP);
  assign vec_stb    = (st == S_FHI) | (st == S_FLO);
  assign vec_is_rst = vec_stb & vrst;
  assign vec_addr   = !vec_stb ? 16'h0000 : (st == S_FLO) ? vbase + 16'd1 : vbase;

endmodule

module lpm_wake_ctrl_chk (
  input logic        clk,
  input logic        por_n,
  input logic        ext_rst_n,
  input logic        wdog_to,
  input logic        lvi_trip,
  input logic        osc_in_stop,
  input logic        cpu_clk_en,
  input logic        tb_clk_en,
  input logic        tb_reg_en,
  input logic        vec_is_rst,
  input logic        vec_stb,
  input logic [15:0] vec_addr
);

  wire rst_src = ~ext_rst_n | wdog_to | lvi_trip;

  AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!por_n)
    $rose(vec_stb) && !rst_src |=> vec_stb && (vec_addr == $past(vec_addr) + 16'd1)); // R3
  AST_FETCH_LEN: assert property (@(posedge clk) disable iff (!por_n)
    vec_stb && $past(vec_stb) |=> !vec_stb); // R3
  AST_FETCH_CLK: assert property (@(posedge clk) disable iff (!por_n)
    vec_stb |-> cpu_clk_en); // R3
  AST_TBREG_HALT: assert property (@(posedge clk) disable iff (!por_n)
    !tb_reg_en |-> !cpu_clk_en); // R9
  AST_TBCLK_GATE: assert property (@(posedge clk) disable iff (!por_n)
    !tb_clk_en |-> !tb_reg_en && !osc_in_stop); // R8
  AST_RST_HALT: assert property (@(posedge clk) disable iff (!por_n)
    rst_src |=> !cpu_clk_en && !vec_stb); // R10
  AST_RST_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    vec_is_rst |-> vec_stb && (vec_addr[15:1] == 15'h7FFF)); // R1

endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdog_to(wdog_to),
  .lvi_trip(lvi_trip), .osc_in_stop(osc_in_stop), .cpu_clk_en(cpu_clk_en),
  .tb_clk_en(tb_clk_en), .tb_reg_en(tb_reg_en), .vec_is_rst(vec_is_rst),
  .vec_stb(vec_stb), .vec_addr(vec_addr)
);

// File: tb/lpm_wake_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_tb;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, irq_n = 1'b1, brk_req = 1'b0;
  logic wdog_to = 1'b0, lvi_trip = 1'b0, cgen_irq = 1'b0, tb_tick = 1'b0;
  logic osc_in_stop = 1'b0, wait_req = 1'b0, stop_req = 1'b0;
  logic cpu_clk_en, tb_clk_en, tb_reg_en, vec_is_rst, vec_stb;
  logic [15:0] vec_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit pend = 0;

  always #2.5 clk = ~clk;

  lpm_wake_ctrl u_dut (.*);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_fetch(string req, logic [15:0] a, logic r);
    check({req, " stb hi"}, vec_stb, 1);
    check({req, " addr hi"}, vec_addr, a);
    check({req, " rstflag"}, vec_is_rst, r);
    check("R3 clk in fetch", cpu_clk_en, 1);
    step();
    check("R3 stb lo", vec_stb, 1);
    check({req, " addr lo"}, vec_addr, a + 16'd1);
    step();
    check("R3 fetch end", vec_stb, 0);
    check("R3 cpu runs", cpu_clk_en, 1);
  endtask

  task automatic irq_pulse();
    irq_n = 1'b0; step(); step();
    irq_n = 1'b1; repeat (4) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    step();
    // R1 reset state
    check("R1 por clk off", cpu_clk_en, 0);
    check("R1 por no stb", vec_stb, 0);
    step();
    por_n = 1'b1;
    step();
    expect_fetch("R1 por vec", 16'hFFFE, 1);

    // R2 both requests: stop wins
    wait_req = 1; stop_req = 1; step(); wait_req = 0; stop_req = 0;
    check("R2 clk off", cpu_clk_en, 0);
    check("R2 stop wins", tb_reg_en, 0);
    brk_req = 1; step(); brk_req = 0;
    expect_fetch("R4 brk", 16'hFFFC, 0);

    // Sweep: mode x osc x {brk, irq, cgen, tick}
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 16; s++) begin
          logic [15:0] ev;
          bit hit;
          osc_in_stop = o[0];
          if (s[1]) begin irq_pulse(); pend = 1; end
          if (m == 1) stop_req = 1; else wait_req = 1;
          brk_req = s[0]; cgen_irq = s[2]; tb_tick = s[3];
          step();
          stop_req = 0; wait_req = 0;
          check("R2 halt", cpu_clk_en, 0);
          check("R9 tbreg", tb_reg_en, (m == 1) ? 0 : 1);
          check("R8 tbclk", tb_clk_en, (m == 1 && o == 0) ? 0 : 1);
          hit = 1;
          if (s[0]) ev = 16'hFFFC;
          else if (pend) begin ev = 16'hFFFA; pend = 0; end
          else if (s[2] && m == 0) ev = 16'hFFF8;
          else if (s[3] && (m == 0 || o == 1)) ev = 16'hFFF6;
          else begin ev = 16'h0; hit = 0; end
          step();
          if (hit) expect_fetch("R5 R6 R7 wake", ev, 0);
          else begin
            repeat (3) begin check("R7 no wake", vec_stb, 0); step(); end
            brk_req = 1; step();
            expect_fetch("R4 rescue", 16'hFFFC, 0);
          end
          brk_req = 0; cgen_irq = 0; tb_tick = 0;
          step();
        end

    // R6 pin held low does not re-trigger
    irq_n = 1'b0; repeat (4) step();
    wait_req = 1; step(); wait_req = 0;
    step();
    expect_fetch("R6 edge", 16'hFFFA, 0);
    wait_req = 1; step(); wait_req = 0;
    repeat (4) begin check("R6 held low", vec_stb, 0); step(); end
    irq_n = 1'b1;
    brk_req = 1; step(); brk_req = 0;
    expect_fetch("R6 exit", 16'hFFFC, 0);

    // R10 watchdog from stop, beating break, held
    irq_pulse();
    stop_req = 1; step(); stop_req = 0;
    wdog_to = 1; brk_req = 1; step();
    check("R10 wdog halt", cpu_clk_en, 0);
    check("R10 wdog nostb", vec_stb, 0);
    step(); step();
    check("R10 held", cpu_clk_en, 0);
    wdog_to = 0; brk_req = 0; step();
    expect_fetch("R10 wdog vec", 16'hFFFE, 1);
    // pending edge was cleared by reset
    wait_req = 1; step(); wait_req = 0;
    repeat (3) begin check("R10 pend cleared", vec_stb, 0); step(); end

    // R10 low-voltage trip from wait
    lvi_trip = 1; step();
    check("R10 lvi halt", cpu_clk_en, 0);
    lvi_trip = 0; step();
    expect_fetch("R10 lvi vec", 16'hFFFE, 1);

    // R10 external reset pin from run
    ext_rst_n = 0; step();
    check("R10 pin halt", cpu_clk_en, 0);
    step();
    check("R10 pin held", vec_stb, 0);
    ext_rst_n = 1; step();
    expect_fetch("R10 pin vec", 16'hFFFE, 1);

    finish_run();
  end

endmodule